// File: doc/BRIEF.md
# Periodic Output Impedance Calibration Controller

This block keeps the strength codes of an output driver matched to an external reference while the pin carries traffic. A free-running cycle counter starts an evaluation at a fixed interval. At each evaluation the block reads a comparator verdict for the pull-up leg and one for the pull-down leg. It then moves each leg's binary-weighted code by one LSB toward the target. Calibration never stops, so slow drift in supply and temperature is followed for as long as the part runs.

A newly computed code is never applied to a leg that is driving. It waits in a pending register and is applied in the first cycle in which that leg is idle. The pull-down leg is idle while the pin drives a 1 or is in high impedance. The pull-up leg is idle while the pin drives a 0 or is in high impedance. Because of this rule the pin cannot glitch during a calibration step. The two active codes drive the leg weights directly. A one-cycle strobe tells the pad logic that a weight has just changed.

Top module: `zcal_ctrl`

## Requirements
- R1: After reset both active codes equal mid-scale 32 (6'b100000), the strobe is 0 and the interval counter is zero.
- R2: An evaluation samples the comparator inputs at rising edge number 1024 after reset is released, and again every 1024 edges after that (parameter INTERVAL, default 1024). A code never changes at any earlier edge.
- R3: A comparator input of 1 ("leg too weak") makes the new code the current code plus 1. An input of 0 ("leg too strong") makes it the current code minus 1. This is one LSB per evaluation.
- R4: Codes saturate: a step up from 63 stays at 63 and a step down from 0 stays at 0. A code never wraps.
- R5: The pull-down code changes only at an edge that closes a cycle in which pad_oe is 0 or pad_dat is 1.
- R6: The pull-up code changes only at an edge that closes a cycle in which pad_oe is 0 or pad_dat is 0.
- R7: A pending code becomes active at the edge that closes the first cycle in which its leg is idle. If the leg is already idle, this is the edge after the evaluation edge.
- R8: A later evaluation replaces a pending code that was never applied. Each step is taken from the code that is active, or that becomes active in that same cycle, so an active code moves by at most one LSB per evaluation.
- R9: code_upd is 1 for exactly the one cycle in which a new value of either active code first appears. It stays 0 when an evaluation leaves both codes unchanged, such as at saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_oe | input | 1 | 1 while the pin drives; 0 while it is in high impedance |
| pad_dat | input | 1 | Level driven on the pin when pad_oe is 1 |
| pu_weak | input | 1 | Comparator verdict for the pull-up leg: 1 too weak, 0 too strong |
| pd_weak | input | 1 | Comparator verdict for the pull-down leg: 1 too weak, 0 too strong |
| pu_code | output | 6 | Active pull-up strength code |
| pd_code | output | 6 | Active pull-down strength code |
| code_upd | output | 1 | One-cycle strobe when either active code changes |

## Verification
Every cycle the assertions check the reset values, that each active code moves by exactly one LSB when it moves, that a code changes only after a cycle in which its leg was idle, and that the strobe matches a change of either code. Only the bench scenarios can show the rest. These are the exact 1024-cycle spacing of evaluations, the direction of each step set by the comparator, saturation at both ends, and the deferral of a pending code until the pin level frees its leg. They also cover the replacement of a stale pending value by a later evaluation.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

    typedef enum logic {
        LEG_PU = 1'b0,
        LEG_PD = 1'b1
    } leg_sel_e;

    // A leg may take a new weight only while it is not the one driving.
    function automatic logic leg_idle(leg_sel_e leg, logic oe, logic dat);
        logic res;
        if (!oe) begin
            res = 1'b1;
        end else if (leg == LEG_PU) begin
            res = !dat;
        end else begin
            res = dat;
        end
        return res;
    endfunction

endpackage

// File: rtl/zcal_interval.sv
module zcal_interval #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_state_t;

    ivl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);

endmodule

// File: rtl/zcal_leg.sv
module zcal_leg
    import zcal_pkg::*;
#(
    parameter int       CODE_W = 6,
    parameter leg_sel_e LEG    = LEG_PU
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic              weak_i,
    input  logic              oe_i,
    input  logic              dat_i,
    output logic [CODE_W-1:0] code_o,
    output logic              changed_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] act;
        logic [CODE_W-1:0] pend;
        logic              vld;
    } leg_state_t;

    leg_state_t st_d, st_q;

    logic              idle;
    logic              apply;
    logic [CODE_W-1:0] base;
    logic [CODE_W-1:0] stepped;

    always_comb begin
        idle  = leg_idle(LEG, oe_i, dat_i);
        apply = st_q.vld && idle;
        // step from the value that is active after this edge
        base  = apply ? st_q.pend : st_q.act;

        if (weak_i) begin
            stepped = (base == CODE_MAX) ? base : base + 1'b1;
        end else begin
            stepped = (base == '0) ? base : base - 1'b1;
        end

        st_d = st_q;
        if (apply) begin
            st_d.act = st_q.pend;
            st_d.vld = 1'b0;
        end
        if (eval_i) begin
            st_d.pend = stepped;
            st_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act  <= CODE_MID;
            st_q.pend <= CODE_MID;
            st_q.vld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o    = st_q.act;
    assign changed_o = (st_d.act != st_q.act);

endmodule

// File: rtl/zcal_ctrl.sv
module zcal_ctrl
    import zcal_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int INTERVAL = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_oe,
    input  logic              pad_dat,
    input  logic              pu_weak,
    input  logic              pd_weak,
    output logic [CODE_W-1:0] pu_code,
    output logic [CODE_W-1:0] pd_code,
    output logic              code_upd
);
    localparam int NLEG = 2;

    typedef struct packed {
        logic upd;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                           eval_tick;
    logic [NLEG-1:0]                weak_vec;
    logic [NLEG-1:0]                chg_vec;
    logic [NLEG-1:0][CODE_W-1:0]    code_vec;

    assign weak_vec[0] = pu_weak;
    assign weak_vec[1] = pd_weak;

    zcal_interval #(
        .INTERVAL (INTERVAL)
    ) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (eval_tick)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        zcal_leg #(
            .CODE_W (CODE_W),
            .LEG    ((g == 0) ? LEG_PU : LEG_PD)
        ) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .eval_i    (eval_tick),
            .weak_i    (weak_vec[g]),
            .oe_i      (pad_oe),
            .dat_i     (pad_dat),
            .code_o    (code_vec[g]),
            .changed_o (chg_vec[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = |chg_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pu_code  = code_vec[0];
    assign pd_code  = code_vec[1];
    assign code_upd = st_q.upd;

endmodule

// File: rtl/zcal_ctrl_chk.sv
module zcal_ctrl_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pad_oe,
    input logic              pad_dat,
    input logic [CODE_W-1:0] pu_code,
    input logic [CODE_W-1:0] pd_code,
    input logic              code_upd
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (pu_code == MID && pd_code == MID && !code_upd));

    // R3
    pu_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_code != $past(pu_code)) |->
        (pu_code == $past(pu_code) + 1'b1 || pu_code == $past(pu_code) - 1'b1));

    // R3
    pd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_code != $past(pd_code)) |->
        (pd_code == $past(pd_code) + 1'b1 || pd_code == $past(pd_code) - 1'b1));

    // R6
    pu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_code != $past(pu_code)) |-> ($past(!pad_oe) || $past(!pad_dat)));

    // R5
    pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_code != $past(pd_code)) |-> ($past(!pad_oe) || $past(pad_dat)));

    // R9
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd == ((pu_code != $past(pu_code)) || (pd_code != $past(pd_code))));

endmodule

bind zcal_ctrl zcal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_oe   (pad_oe),
    .pad_dat  (pad_dat),
    .pu_code  (pu_code),
    .pd_code  (pd_code),
    .code_upd (code_upd)
);

// File: tb/zcal_ctrl_tb.sv
`timescale 1ns/1ps
module zcal_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_oe = 1'b0;
    logic       pad_dat = 1'b0;
    logic       pu_weak = 1'b0;
    logic       pd_weak = 1'b0;
    logic [5:0] pu_code;
    logic [5:0] pd_code;
    logic       code_upd;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    zcal_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_oe   (pad_oe),
        .pad_dat  (pad_dat),
        .pu_weak  (pu_weak),
        .pd_weak  (pd_weak),
        .pu_code  (pu_code),
        .pd_code  (pd_code),
        .code_upd (code_upd)
    );

    typedef struct packed {
        logic       oe;
        logic       dat;
        logic       puw;
        logic       pdw;
        logic [5:0] pu;
        logic [5:0] pd;
    } vec_t;

    // one row per evaluation period; expected codes after the apply edge
    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 6'd33, 6'd33},
        '{1'b0, 1'b0, 1'b0, 1'b1, 6'd32, 6'd34},
        '{1'b1, 1'b1, 1'b1, 1'b0, 6'd32, 6'd33},
        '{1'b1, 1'b1, 1'b0, 1'b0, 6'd32, 6'd32},
        '{1'b1, 1'b0, 1'b1, 1'b1, 6'd32, 6'd32},
        '{1'b0, 1'b0, 1'b0, 1'b0, 6'd31, 6'd32},
        '{1'b1, 1'b0, 1'b0, 1'b1, 6'd30, 6'd32},
        '{1'b1, 1'b1, 1'b1, 1'b1, 6'd30, 6'd34}
    };

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    task automatic drive(input logic oe, input logic dat, input logic puw, input logic pdw);
        pad_oe  = oe;
        pad_dat = dat;
        pu_weak = puw;
        pd_weak = pdw;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset values
        cyc(1);
        check("R1 pu reset", int'(pu_code), 32);
        check("R1 pd reset", int'(pd_code), 32);
        check("R1 strobe reset", int'(code_upd), 0);
        do_reset();

        // R3 R5 R6 R7 R8: table walk, one evaluation per row
        for (int i = 0; i < 8; i++) begin
            drive(VEC[i].oe, VEC[i].dat, VEC[i].puw, VEC[i].pdw);
            cyc(i == 0 ? 1025 : 1024);
            check($sformatf("R8 row %0d pu", i), int'(pu_code), int'(VEC[i].pu));
            check($sformatf("R8 row %0d pd", i), int'(pd_code), int'(VEC[i].pd));
        end

        // R2 R9: evaluation spacing and strobe width
        do_reset();
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        cyc(1024);
        check("R2 no change before apply", int'(pu_code), 32);
        cyc(1);
        check("R2 first step", int'(pu_code), 33);
        check("R9 strobe high", int'(code_upd), 1);
        cyc(1);
        check("R9 strobe one cycle", int'(code_upd), 0);
        cyc(1021);
        check("R2 no early second step", int'(pd_code), 33);
        cyc(2);
        check("R2 second step pu", int'(pu_code), 34);
        check("R2 second step pd", int'(pd_code), 34);

        // R6 R7: pull-up held while the pin drives 1, applied on first idle cycle
        do_reset();
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        cyc(1025);
        check("R6 pu held while driving 1", int'(pu_code), 32);
        check("R5 pd applied while driving 1", int'(pd_code), 33);
        cyc(5);
        check("R6 pu still held", int'(pu_code), 32);
        pad_dat = 1'b0;
        cyc(1);
        check("R7 pu applied on first idle cycle", int'(pu_code), 33);
        check("R7 strobe on deferred apply", int'(code_upd), 1);
        check("R5 pd unchanged while driving 0", int'(pd_code), 33);

        // R4: saturation at both ends
        do_reset();
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1025);
        for (int k = 0; k < 39; k++) cyc(1024);
        check("R4 pu saturates at 63", int'(pu_code), 63);
        check("R4 pd saturates at 0", int'(pd_code), 0);
        check("R9 no strobe at saturation", int'(code_upd), 0);

        // R1: reset mid-run restores mid-scale
        do_reset();
        cyc(1);
        check("R1 pu after second reset", int'(pu_code), 32);
        check("R1 pd after second reset", int'(pd_code), 32);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule